// File: doc/BRIEF.md
# Serial Pattern Recognizer With Lockout

This block watches a single-bit serial stream, taking one bit on every rising clock edge, and raises a flag each time the three most recently taken bits are 0, 1, 0 in arrival order. Matches may overlap, so the middle 0 of one match can serve as the first 0 of the next. If the three most recent bits are ever 1, 0, 0, the block enters a lockout state. It then stays there, with the flag low, until a synchronous reset clears it.

The flag is a Moore output: it depends on the registered state alone, so it appears in the cycle after the edge that took the final bit. The 3-bit state code is brought out on a port so that the surrounding logic can observe how far the recognizer has progressed. The input is a plain level with no handshake. Every clock edge consumes exactly one bit, and the block has no back-pressure to exert.

Top module: `seq_lock_detect`

## Requirements
- R1: With `rst` high at a rising edge, the block shows `state_obs` = 000 and `hit` = 0 after that edge.
- R2: After the edge that takes a bit, `hit` is 1 exactly when at least three bits have been taken since reset, the last three taken are 0,1,0 (oldest first), and 1,0,0 has not occurred as three consecutive bits since reset.
- R3: Overlapping matches count: the stream 0,1,0,1,0 gives `hit` = 1 after the third bit and after the fifth bit.
- R4: Once 1,0,0 has been taken, `state_obs` reads 110 and `hit` stays 0 for any further input until reset.
- R5: State codes on `state_obs`: 000 means nothing taken, 001 means ends in 0 with no 1 seen, 010 means ends in 01, 011 means ends in 010, 100 means ends in 1 with no 0 after it, 101 means ends in 10, and 110 means locked.
- R6: `state_obs` never reads 111. An out-of-range code returns to 000 at the next edge.
- R7: Reset takes priority over the input: an edge with `rst` high clears the state even if the bit on that edge would complete a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit, taken on each rising edge |
| hit | output | 1 | High while the history ends in 0,1,0 with no lockout |
| state_obs | output | 3 | Current recognizer state code |

## Verification
Two events can land on the same edge. The first is the loss of a match combined with entry into lockout: a 0 arriving just after 0,1,0 both drops `hit` and makes the history end in 1,0,0. The bench drives exactly that sequence and then checks that `hit` falls and `state_obs` reads 110 on the same edge. The second is a reset that coincides with the bit that would complete 0,1,0; the bench expects the cleared state and no flag.

// File: rtl/seq_lock_detect_pkg.sv
package seq_lock_detect_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 3'b000,
    ST_Z      = 3'b001,
    ST_ZO     = 3'b010,
    ST_ZOZ    = 3'b011,
    ST_O      = 3'b100,
    ST_OZ     = 3'b101,
    ST_LOCKED = 3'b110,
    ST_BAD    = 3'b111
  } rec_state_e;
endpackage

// File: rtl/seq_lock_next.sv
module seq_lock_next
  import seq_lock_detect_pkg::*;
(
  input  rec_state_e cur,
  input  logic       din,
  output rec_state_e nxt
);
  always_comb begin
    unique case (cur)
      ST_IDLE:   nxt = din ? ST_O  : ST_Z;
      ST_Z:      nxt = din ? ST_ZO : ST_Z;
      ST_ZO:     nxt = din ? ST_O  : ST_ZOZ;
      ST_ZOZ:    nxt = din ? ST_ZO : ST_LOCKED;
      ST_O:      nxt = din ? ST_O  : ST_OZ;
      ST_OZ:     nxt = din ? ST_ZO : ST_LOCKED;
      ST_LOCKED: nxt = ST_LOCKED;
      default:   nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/seq_lock_reg.sv
module seq_lock_reg
  import seq_lock_detect_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rec_state_e nxt,
  output rec_state_e cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= ST_IDLE;
    else     cur <= nxt;
  end
endmodule

// File: rtl/seq_lock_decode.sv
module seq_lock_decode
  import seq_lock_detect_pkg::*;
(
  input  rec_state_e           cur,
  output logic                 flag,
  output logic [STATE_W-1:0]   code
);
  assign flag = (cur == ST_ZOZ);
  assign code = cur;
endmodule

// File: rtl/seq_lock_detect.sv
module seq_lock_detect
  import seq_lock_detect_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_in,
  output logic               hit,
  output logic [STATE_W-1:0] state_obs
);
  rec_state_e cur_q;
  rec_state_e nxt_d;

  seq_lock_next u_next (
    .cur (cur_q),
    .din (bit_in),
    .nxt (nxt_d)
  );

  seq_lock_reg u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_d),
    .cur (cur_q)
  );

  seq_lock_decode u_dec (
    .cur  (cur_q),
    .flag (hit),
    .code (state_obs)
  );
endmodule

// File: rtl/seq_lock_detect_chk.sv
module seq_lock_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_in,
  input logic       hit,
  input logic [2:0] state_obs
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (state_obs == 3'b000 && !hit));

  assert_hit_prefix_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> (!$past(bit_in) && $past(bit_in, 2)));

  assert_overlap_step_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && bit_in) |=> state_obs == 3'b010);

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (state_obs == 3'b110) |=> (state_obs == 3'b110 && !hit));

  assert_lock_entry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(state_obs == 3'b110) |-> !$past(bit_in));

  assert_hit_code_R5: assert property (@(posedge clk) disable iff (rst)
    hit |-> state_obs == 3'b011);

  assert_no_bad_code_R6: assert property (@(posedge clk) disable iff (rst)
    state_obs != 3'b111);
endmodule

bind seq_lock_detect seq_lock_detect_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_in    (bit_in),
  .hit       (hit),
  .state_obs (state_obs)
);

// File: tb/seq_lock_detect_tb.sv
module seq_lock_detect_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_in = 1'b0;
  logic       hit;
  logic [2:0] state_obs;

  int checks = 0;
  int fails  = 0;
  logic [2:0] hist;
  int         cnt;
  logic       locked;

  always #10 clk = ~clk;

  seq_lock_detect u_dut (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .hit       (hit),
    .state_obs (state_obs)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Called at a negedge; leaves off at a negedge.
  task automatic do_reset();
    rst = 1'b1;
    bit_in = 1'b1;
    @(posedge clk); #5;
    check("R1 state", state_obs, 3'b000);
    check("R1 hit", {2'b00, hit}, 3'b000);
    @(negedge clk);
    rst = 1'b0;
    hist = 3'b000; cnt = 0; locked = 1'b0;
  endtask

  task automatic push_bit(input logic b, input string req);
    logic e;
    bit_in = b;
    hist = {hist[1:0], b};
    cnt++;
    if (cnt >= 3 && hist == 3'b100) locked = 1'b1;
    e = (cnt >= 3) && (hist == 3'b010) && !locked;
    @(posedge clk); #5;
    check(req, {2'b00, hit}, {2'b00, e});
    if (state_obs == 3'b111) check("R6 bad code", state_obs, 3'b000);
    if (locked) check("R4 locked code", state_obs, 3'b110);
    @(negedge clk);
  endtask

  task automatic push_word(input logic [15:0] w, input int n, input string req);
    for (int i = n - 1; i >= 0; i--) push_bit(w[i], req);
  endtask

  task automatic t_stream_a();
    do_reset();
    push_word(16'b00101010010, 11, "R2 stream a");
  endtask

  task automatic t_stream_b();
    do_reset();
    push_word(16'b11011010010, 11, "R2 stream b");
  endtask

  task automatic t_overlap();
    do_reset();
    push_word(16'b01010, 5, "R3 overlap");
    push_bit(1'b1, "R3 overlap");
    push_bit(1'b0, "R3 overlap");
    check("R3 ends-in-010 code", state_obs, 3'b011);
  endtask

  task automatic t_lock_hold();
    do_reset();
    push_word(16'b010, 3, "R4 pre");
    push_bit(1'b0, "R4 lock entry");
    check("R4 lock same edge", state_obs, 3'b110);
    push_word(16'b0101001011010100, 16, "R4 hold");
  endtask

  task automatic t_codes();
    do_reset();
    push_bit(1'b0, "R5"); check("R5 ends-in-0", state_obs, 3'b001);
    push_bit(1'b0, "R5"); check("R5 ends-in-0 loop", state_obs, 3'b001);
    push_bit(1'b1, "R5"); check("R5 ends-in-01", state_obs, 3'b010);
    push_bit(1'b1, "R5"); check("R5 ends-in-1", state_obs, 3'b100);
    push_bit(1'b1, "R5"); check("R5 ends-in-1 loop", state_obs, 3'b100);
    push_bit(1'b0, "R5"); check("R5 ends-in-10", state_obs, 3'b101);
    push_bit(1'b1, "R5"); check("R5 10 then 1", state_obs, 3'b010);
    push_bit(1'b0, "R5"); check("R5 ends-in-010", state_obs, 3'b011);
    do_reset();
    push_bit(1'b1, "R5"); check("R5 first 1", state_obs, 3'b100);
    push_bit(1'b0, "R5");
    push_bit(1'b0, "R5"); check("R5 locked", state_obs, 3'b110);
  endtask

  task automatic t_reset_collide();
    do_reset();
    push_word(16'b01, 2, "R7 pre");
    rst = 1'b1;
    bit_in = 1'b0;
    @(posedge clk); #5;
    check("R7 reset wins state", state_obs, 3'b000);
    check("R7 reset wins hit", {2'b00, hit}, 3'b000);
    @(negedge clk);
    rst = 1'b0;
    hist = 3'b000; cnt = 0; locked = 1'b0;
    push_word(16'b010, 3, "R7 after");
  endtask

  task automatic t_unlock_by_reset();
    do_reset();
    push_word(16'b100, 3, "R4 lock");
    do_reset();
    push_word(16'b0101, 4, "R1 relearn");
  endtask

  initial begin
    @(negedge clk);
    t_stream_a();
    t_stream_b();
    t_overlap();
    t_lock_hold();
    t_codes();
    t_reset_collide();
    t_unlock_by_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule